// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects up to 64 level-sensitive interrupt lines and tells the processor which one to service. Each source has a pending bit that follows its input line, a force bit that software can set, a mask bit, and an 8-bit priority byte. A byte of zero turns the source off. Among the sources that are pending or forced, unmasked and switched on, the controller picks the one with the highest priority byte. It drives that byte as the interrupt level and drives 64 plus the source index as the vector number.

Software reaches the state through a byte-addressed register bus with a 256-byte window. A transfer is a single cycle: a valid strobe, a write strobe, an 8-bit address and a 32-bit data word. The 64-bit registers are split into two 32-bit words. Two byte commands set or clear one mask bit, or all mask bits at once. A read of the acknowledge offset returns the vector currently being driven.

Top module: `prio_intc`

## Requirements
- R1: A source is a candidate only when its pending or force bit is set, its priority byte is nonzero and its mask bit is clear.
- R2: The winner is the candidate with the largest priority byte. When priority bytes are equal, the source with the higher index wins.
- R3: With a winner, `cpu_level_o` is the winner's priority byte and `cpu_vector_o` is 64 plus its index. With no candidate, the level is 0 and the vector is 24.
- R4: Every clock, the pending register samples `irq_i`. Writes to offsets 0x00 and 0x04 have no effect.
- R5: The pending, mask and force registers are readable as 32-bit words. The upper half (bits 63:32) is at 0x00, 0x08 and 0x10, and the lower half at 0x04, 0x0C and 0x14. Mask and force are writable at the same offsets.
- R6: Offset 0x40+n holds the priority byte of source n (written from data bits 7:0, read back zero-extended). Writing zero disables the source; any other value enables it.
- R7: A write to 0x1C sets the mask bit chosen by data bits 5:0. If data bit 6 is 1, it sets all 64 mask bits instead.
- R8: A write to 0x1D clears the mask bit chosen by data bits 5:0. If data bit 6 is 1, it clears the whole mask instead.
- R9: A read of 0xE0 returns the current `cpu_vector_o`. A read of any unlisted offset returns 0, and a write to any unlisted offset changes nothing.
- R10: After reset, the mask is all ones, pending, force and all priority bytes are zero, the level is 0 and the vector is 24.
- R11: The level and vector outputs are registered. They reflect register contents one clock after a register write, and `irq_i` two clocks after a line change. Read data is combinational while `bus_vld_i` is high and `bus_wr_i` is low, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 64 | Level-sensitive interrupt lines, one per source |
| bus_vld_i | input | 1 | Bus transfer valid for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset in the register window |
| bus_wdata_i | input | 32 | Write data; byte commands use bits 7:0 |
| bus_rdata_o | output | 32 | Read data |
| cpu_level_o | output | 8 | Priority level presented to the processor |
| cpu_vector_o | output | 8 | Vector number presented to the processor |

## Verification
The checker watches four things on every cycle:
- the level/vector pairing: a zero level always comes with vector 24, and a nonzero level with a vector in 64..127;
- that the lower pending word read back equals the lines sampled one clock earlier;
- that a read of the acknowledge offset returns the driven vector;
- that the set-all and clear-all mask commands leave the mask fully set or fully cleared.

Selection itself needs the bench's scenarios. These cover ties resolved toward the higher index, a disabled source losing to a lower-priority one, single-bit mask commands, forced sources, ignored writes to pending and unlisted offsets, and the one-clock output latency after a write.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int N_SRC  = 64;
    localparam int LVL_W  = 8;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;

    localparam logic [ADDR_W-1:0] A_PEND_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_FORCE_HI = 8'h10;
    localparam logic [ADDR_W-1:0] A_FORCE_LO = 8'h14;
    localparam logic [ADDR_W-1:0] A_MSET     = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MCLR     = 8'h1D;
    localparam logic [ADDR_W-1:0] A_ACK      = 8'hE0;

    typedef logic [N_SRC-1:0][LVL_W-1:0] prio_arr_t;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } node_t;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } out_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic              bus_vld_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_SRC-1:0]  pend_o,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  force_o,
    output prio_arr_t         prio_o
);
    localparam int HALF = N_SRC / 2;

    typedef struct packed {
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] frc;
        prio_arr_t        prio;
    } st_t;

    st_t st_d, st_q;
    logic wen, ren;

    assign wen = bus_vld_i & bus_wr_i;
    assign ren = bus_vld_i & ~bus_wr_i;

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_i;
        if (wen) begin
            case (bus_addr_i)
                A_MASK_HI:  st_d.mask[N_SRC-1:HALF] = bus_wdata_i;
                A_MASK_LO:  st_d.mask[HALF-1:0]     = bus_wdata_i;
                A_FORCE_HI: st_d.frc[N_SRC-1:HALF]  = bus_wdata_i;
                A_FORCE_LO: st_d.frc[HALF-1:0]      = bus_wdata_i;
                A_MSET: begin
                    if (bus_wdata_i[6]) st_d.mask = '1;
                    else                st_d.mask[bus_wdata_i[IDX_W-1:0]] = 1'b1;
                end
                A_MCLR: begin
                    if (bus_wdata_i[6]) st_d.mask = '0;
                    else                st_d.mask[bus_wdata_i[IDX_W-1:0]] = 1'b0;
                end
                default: begin
                    if (bus_addr_i[7:6] == 2'b01)
                        st_d.prio[bus_addr_i[IDX_W-1:0]] = bus_wdata_i[LVL_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
            st_q.frc  <= '0;
            st_q.prio <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (ren) begin
            case (bus_addr_i)
                A_PEND_HI:  rdata_o = st_q.pend[N_SRC-1:HALF];
                A_PEND_LO:  rdata_o = st_q.pend[HALF-1:0];
                A_MASK_HI:  rdata_o = st_q.mask[N_SRC-1:HALF];
                A_MASK_LO:  rdata_o = st_q.mask[HALF-1:0];
                A_FORCE_HI: rdata_o = st_q.frc[N_SRC-1:HALF];
                A_FORCE_LO: rdata_o = st_q.frc[HALF-1:0];
                A_ACK:      rdata_o = {{(DATA_W-VEC_W){1'b0}}, vec_i};
                default: begin
                    if (bus_addr_i[7:6] == 2'b01)
                        rdata_o = {{(DATA_W-LVL_W){1'b0}}, st_q.prio[bus_addr_i[IDX_W-1:0]]};
                end
            endcase
        end
    end

    assign pend_o  = st_q.pend;
    assign mask_o  = st_q.mask;
    assign force_o = st_q.frc;
    assign prio_o  = st_q.prio;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
(
    input  logic [N_SRC-1:0] cand_i,
    input  prio_arr_t        prio_i,
    output node_t            win_o
);
    localparam int NODES = 2 * N_SRC - 1;
    localparam int LEAF0 = N_SRC - 1;

    node_t nd [NODES];

    for (genvar j = 0; j < N_SRC; j++) begin : g_leaf
        always_comb begin
            nd[LEAF0+j].vld = cand_i[j];
            nd[LEAF0+j].lvl = prio_i[j];
            nd[LEAF0+j].idx = IDX_W'(j);
        end
    end

    // Left child covers lower indices; right wins ties.
    for (genvar i = 0; i < N_SRC - 1; i++) begin : g_node
        always_comb begin
            if (nd[2*i+2].vld && (!nd[2*i+1].vld || nd[2*i+2].lvl >= nd[2*i+1].lvl))
                nd[i] = nd[2*i+2];
            else
                nd[i] = nd[2*i+1];
        end
    end

    assign win_o = nd[0];
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int VEC_BASE = 64,
    parameter int VEC_IDLE = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] irq_i,
    input  logic        bus_vld_i,
    input  logic        bus_wr_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic [7:0]  cpu_level_o,
    output logic [7:0]  cpu_vector_o
);
    logic [N_SRC-1:0] pend_w, mask_w, force_w, en_w, cand_w;
    prio_arr_t        prio_w;
    node_t            win_w;
    out_t             out_d, out_q;

    intc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .bus_vld_i   (bus_vld_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .vec_i       (out_q.vec),
        .rdata_o     (bus_rdata_o),
        .pend_o      (pend_w),
        .mask_o      (mask_w),
        .force_o     (force_w),
        .prio_o      (prio_w)
    );

    for (genvar k = 0; k < N_SRC; k++) begin : g_en
        assign en_w[k] = |prio_w[k];
    end

    assign cand_w = (pend_w | force_w) & en_w & ~mask_w;

    intc_arb u_arb (
        .cand_i (cand_w),
        .prio_i (prio_w),
        .win_o  (win_w)
    );

    always_comb begin
        out_d = out_q;
        if (win_w.vld) begin
            out_d.lvl = win_w.lvl;
            out_d.vec = VEC_W'(VEC_BASE) + VEC_W'(win_w.idx);
        end else begin
            out_d.lvl = '0;
            out_d.vec = VEC_W'(VEC_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.lvl <= '0;
            out_q.vec <= VEC_W'(VEC_IDLE);
        end else begin
            out_q <= out_d;
        end
    end

    assign cpu_level_o  = out_q.lvl;
    assign cpu_vector_o = out_q.vec;
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] irq_lo,
    input logic        bus_vld_i,
    input logic        bus_wr_i,
    input logic [7:0]  bus_addr_i,
    input logic [7:0]  wbyte,
    input logic [31:0] bus_rdata_o,
    input logic [7:0]  cpu_level_o,
    input logic [7:0]  cpu_vector_o,
    input logic [63:0] mask_q
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level_o == 8'd0) |-> (cpu_vector_o == 8'd24)); // R3
    AST_ACTIVE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level_o != 8'd0) |-> (cpu_vector_o >= 8'd64 && cpu_vector_o < 8'd128)); // R3
    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && bus_vld_i && !bus_wr_i && bus_addr_i == 8'h04) |-> (bus_rdata_o == $past(irq_lo))); // R4
    AST_ACK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld_i && !bus_wr_i && bus_addr_i == 8'hE0) |-> (bus_rdata_o == {24'd0, cpu_vector_o})); // R9
    AST_MASK_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && bus_vld_i && bus_wr_i && bus_addr_i == 8'h1C && wbyte[6]) |=> (mask_q == '1)); // R7
    AST_MASK_ALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && bus_vld_i && bus_wr_i && bus_addr_i == 8'h1D && wbyte[6]) |=> (mask_q == '0)); // R8
endmodule

bind prio_intc intc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_lo       (irq_i[31:0]),
    .bus_vld_i    (bus_vld_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .wbyte        (bus_wdata_i[7:0]),
    .bus_rdata_o  (bus_rdata_o),
    .cpu_level_o  (cpu_level_o),
    .cpu_vector_o (cpu_vector_o),
    .mask_q       (mask_w)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_i = '0;
    logic        bus_vld_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [7:0]  cpu_level_o;
    logic [7:0]  cpu_vector_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    prio_intc dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq_i),
        .bus_vld_i    (bus_vld_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .cpu_level_o  (cpu_level_o),
        .cpu_vector_o (cpu_vector_o)
    );

    // {irq lines, expected level, expected vector}
    // priorities: src5=3, src10=3, src40=7, src63=1, src2=0
    localparam int NV = 8;
    localparam logic [79:0] VEC_TBL [NV] = '{
        {64'h0, 8'd0, 8'd24},
        {64'h0000_0000_0000_0020, 8'd3, 8'd69},
        {64'h0000_0000_0000_0420, 8'd3, 8'd74},
        {64'h0000_0100_0000_0420, 8'd7, 8'd104},
        {64'h8000_0000_0000_0000, 8'd1, 8'd127},
        {64'h0000_0000_0000_0004, 8'd0, 8'd24},
        {64'h8000_0000_0000_0020, 8'd3, 8'd69},
        {64'h8000_0000_0000_0004, 8'd1, 8'd127}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [7:0] lvl, input logic [7:0] vec);
        chk({req, " level"}, {56'd0, cpu_level_o}, {56'd0, lvl});
        chk({req, " vector"}, {56'd0, cpu_vector_o}, {56'd0, vec});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_vld_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_vld_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_vld_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_vld_i = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk_out("R10 reset", 8'd0, 8'd24);
        rd(8'h08, r); chk("R10 mask hi", {32'd0, r}, 64'hFFFF_FFFF);
        rd(8'h0C, r); chk("R10 mask lo", {32'd0, r}, 64'hFFFF_FFFF);
        rd(8'h14, r); chk("R10 force lo", {32'd0, r}, 64'd0);
        rd(8'h45, r); chk("R10 prio byte", {32'd0, r}, 64'd0);
        rd(8'hE0, r); chk("R10 R9 ack", {32'd0, r}, 64'd24);

        // configure
        wr(8'h45, 32'd3);
        wr(8'h4A, 32'd3);
        wr(8'h68, 32'hFFFF_FF07);   // upper data bits dropped
        wr(8'h7F, 32'd1);
        irq_i = 64'h0000_0000_0000_0020;
        settle();
        chk_out("R1 masked source not a candidate", 8'd0, 8'd24);
        wr(8'h1D, 32'h40);
        rd(8'h68, r); chk("R6 prio readback", {32'd0, r}, 64'd7);

        // R1 R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            irq_i = VEC_TBL[i][79:16];
            settle();
            chk_out($sformatf("R2 R3 vector %0d", i), VEC_TBL[i][15:8], VEC_TBL[i][7:0]);
        end

        // R11 latency from irq change
        irq_i = 64'h0;
        settle();
        irq_i = 64'h0000_0000_0000_0020;
        @(negedge clk);
        chk_out("R11 one clock after line", 8'd0, 8'd24);
        @(negedge clk);
        chk_out("R11 two clocks after line", 8'd3, 8'd69);
        rd(8'hE0, r); chk("R9 ack vector", {32'd0, r}, 64'd69);

        // R4 pending readback and ignored write
        irq_i = 64'hA5A5_0000_0000_0420;
        settle();
        rd(8'h00, r); chk("R4 R5 pend hi", {32'd0, r}, 64'hA5A5_0000);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, r); chk("R4 pend write ignored", {32'd0, r}, 64'h0000_0420);
        chk_out("R4 outputs after pend write", 8'd3, 8'd74);

        // R7 R8 single-bit mask commands
        irq_i = 64'h0000_0100_0000_0420;
        settle();
        wr(8'h1C, 32'd40);
        @(negedge clk);
        chk_out("R7 single mask set", 8'd3, 8'd74);
        rd(8'h08, r); chk("R7 R5 mask hi", {32'd0, r}, 64'h0000_0100);
        wr(8'h1D, 32'd40);
        @(negedge clk);
        chk_out("R8 single mask clear", 8'd7, 8'd104);
        wr(8'h1C, 32'h40);
        @(negedge clk);
        chk_out("R7 mask all", 8'd0, 8'd24);
        rd(8'h0C, r); chk("R7 mask lo all ones", {32'd0, r}, 64'hFFFF_FFFF);
        wr(8'h1D, 32'h40);
        rd(8'h08, r); chk("R8 mask hi cleared", {32'd0, r}, 64'd0);

        // R11 one clock after write, R6 disable
        wr(8'h68, 32'd0);
        chk_out("R11 before output update", 8'd7, 8'd104);
        @(negedge clk);
        chk_out("R6 disabled source", 8'd3, 8'd74);
        wr(8'h68, 32'd7);

        // R5 force register
        irq_i = 64'h0;
        wr(8'h14, 32'h0000_0400);
        settle();
        chk_out("R1 R5 forced lo", 8'd3, 8'd74);
        wr(8'h10, 32'h0000_0100);
        settle();
        chk_out("R1 R5 forced hi", 8'd7, 8'd104);
        rd(8'h10, r); chk("R5 force hi readback", {32'd0, r}, 64'h0000_0100);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        settle();
        chk_out("R5 force cleared", 8'd0, 8'd24);

        // R9 unlisted offsets
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        settle();
        rd(8'h30, r); chk("R9 unlisted read", {32'd0, r}, 64'd0);
        rd(8'h0C, r); chk("R9 unlisted write no mask change", {32'd0, r}, 64'd0);
        rd(8'h14, r); chk("R9 unlisted write no force change", {32'd0, r}, 64'd0);
        chk_out("R9 unlisted write outputs", 8'd0, 8'd24);
        bus_vld_i = 1'b0; bus_addr_i = 8'h68;
        #1 chk("R11 rdata idle", {32'd0, bus_rdata_o}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule